// File: doc/BRIEF.md
# Single-Wire Bus Master Timing Engine

This block produces the bit-level waveforms that a bus master needs on a single open-drain data line with a pull-up resistor. A caller hands it one operation at a time: a bus reset with presence detection, a one-bit write, a one-bit read, or switching a strong pull-up on or off. The engine then times the low pulse on the line, samples the line where required, and pulses `done` when the slot and its recovery time are complete. Byte framing, addressing and CRC handling belong to the layer above.

All timing is counted in microseconds. A divider turns the system clock into a 1 µs tick, and the divider restarts when an operation is accepted, so every edge of every slot lands on an exact multiple of `CLK_PER_US` clock cycles after the accepting edge. The data line is never driven high. `line_drive_low` either pulls it low or releases it, and the strong pull-up output `spu_en` is a separate enable that never overlaps a low drive.

Top module: `line_master_phy`

## Requirements
- R1: After reset the line is released, the strong pull-up is off, `done` is low, and `presence` and `rd_bit` read 0.
- R2: A reset operation (`cmd_op` = 0) drives the line low for 480 µs, releases it, and pulses `done` 960 µs after the accepting edge.
- R3: During a reset operation the line is sampled 70 µs after release (550 µs after start). `presence` becomes 1 if the line is low there and 0 otherwise, and holds until the next reset.
- R4: A write operation (`cmd_op` = 1) with `cmd_bit` = 1 drives low for 6 µs. With `cmd_bit` = 0 it drives low for 60 µs. Both pulse `done` 70 µs after start (a 65 µs slot plus 5 µs recovery).
- R5: A read operation (`cmd_op` = 2) drives low for 6 µs and samples the line 10 µs after start. `rd_bit` takes the sampled level, and `done` pulses at 70 µs.
- R6: A pull-up operation (`cmd_op` = 3) sets `spu_en` to `cmd_bit` and pulses `done` on the next cycle. `spu_en` and `line_drive_low` are never high together.
- R7: While `spu_en` is 1, reset, write and read commands are ignored: the line stays released and no `done` follows.
- R8: Any command that arrives while a slot is in progress is ignored. Each accepted operation produces exactly one single-cycle `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Operation request, taken when the engine is idle |
| cmd_op | input | 2 | Operation code: 0 reset, 1 write, 2 read, 3 pull-up |
| cmd_bit | input | 1 | Bit to write, or pull-up on (1) / off (0) |
| line_in | input | 1 | Level observed on the bus line |
| line_drive_low | output | 1 | 1 pulls the line low, 0 releases it |
| spu_en | output | 1 | Strong pull-up enable |
| rd_bit | output | 1 | Level sampled in the last read slot |
| presence | output | 1 | Presence result of the last reset |
| done | output | 1 | One-cycle pulse when an operation completes |

## Verification
The bench measures the exact number of cycles the line is held low and the cycle in which `done` rises. An off-by-one in the microsecond counter or in the divider restart would therefore shift a count by `CLK_PER_US` cycles and be reported. Read slots are run with a responder that releases the line 1 µs before and 1 µs after the sample point. A design that samples too early or too late returns the wrong `rd_bit`. Presence is checked with a responder inside the window, one that starts too late and no responder, so a latched or inverted flag shows up. Commands are injected mid-slot and while the strong pull-up is on; a design that queued or accepted them would produce an extra `done`, a changed pull-up or a low pulse.

// File: rtl/lmp_pkg.sv
package lmp_pkg;

  typedef enum logic [1:0] {
    OP_RESET  = 2'd0,
    OP_WRITE  = 2'd1,
    OP_READ   = 2'd2,
    OP_PULLUP = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    K_IDLE,
    K_RESET,
    K_WRITE,
    K_READ
  } kind_e;

  // Microseconds the line is pulled low for a given slot kind.
  function automatic int low_span(kind_e k, logic wbit, int rst_low,
                                  int w1_low, int w0_low, int rd_low);
    case (k)
      K_RESET: return rst_low;
      K_WRITE: return wbit ? w1_low : w0_low;
      K_READ:  return rd_low;
      default: return 0;
    endcase
  endfunction

  // Microseconds from start of a slot to its completion (recovery included).
  function automatic int end_span(kind_e k, int rst_total, int slot_total);
    case (k)
      K_RESET: return rst_total;
      K_WRITE,
      K_READ:  return slot_total;
      default: return 1;
    endcase
  endfunction

  // Bits needed to count up to max_us.
  function automatic int us_width(int max_us);
    return (max_us < 2) ? 1 : $clog2(max_us + 1);
  endfunction

endpackage

// File: rtl/lmp_us_tick.sv
module lmp_us_tick #(
  parameter int CLK_PER_US = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  output logic tick
);
  localparam int DW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(CLK_PER_US - 1);

  logic [DW-1:0] div_q;

  assign tick = (div_q == DIV_LAST) && !clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (clear || tick) begin
      div_q <= '0;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/lmp_line_sync.sv
module lmp_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_s
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '1;
    end else begin
      sh_q[0] <= line_in;
      for (int i = 1; i < STAGES; i++) begin
        sh_q[i] <= sh_q[i-1];
      end
    end
  end

  assign line_s = sh_q[STAGES-1];
endmodule

// File: rtl/lmp_slot_seq.sv
module lmp_slot_seq
  import lmp_pkg::*;
#(
  parameter int T_RST_LOW     = 480,
  parameter int T_PRES_SAMPLE = 70,
  parameter int T_W1_LOW      = 6,
  parameter int T_W0_LOW      = 60,
  parameter int T_RD_LOW      = 6,
  parameter int T_RD_SAMPLE   = 10,
  parameter int RST_TOTAL     = 960,
  parameter int SLOT_TOTAL    = 70
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic       cmd_bit,
  input  logic       line_s,
  output logic       tick_clear,
  output logic       line_drive_low,
  output logic       spu_en,
  output logic       rd_bit,
  output logic       presence,
  output logic       done,
  output logic       busy,
  output logic       accept,
  output logic       slot_end,
  output logic       sample_evt
);
  localparam int UW      = us_width(RST_TOTAL);
  localparam int PRES_AT = T_RST_LOW + T_PRES_SAMPLE;

  kind_e         kind_q;
  logic [UW-1:0] us_q;
  logic          wbit_q, spu_q, rd_q, pres_q, done_q;
  int            low_us, end_us;
  logic          rd_evt, pres_evt;
  op_e           op_in;

  assign op_in = op_e'(cmd_op);

  always_comb begin
    low_us = low_span(kind_q, wbit_q, T_RST_LOW, T_W1_LOW, T_W0_LOW, T_RD_LOW);
    end_us = end_span(kind_q, RST_TOTAL, SLOT_TOTAL);
  end

  assign busy       = (kind_q != K_IDLE);
  assign accept     = cmd_valid && !busy && (!spu_q || op_in == OP_PULLUP);
  assign tick_clear = accept;
  assign slot_end   = busy && tick && (int'(us_q) == end_us - 1);
  assign rd_evt     = (kind_q == K_READ) && tick && (int'(us_q) == T_RD_SAMPLE - 1);
  assign pres_evt   = (kind_q == K_RESET) && tick && (int'(us_q) == PRES_AT - 1);
  assign sample_evt = rd_evt || pres_evt;

  assign line_drive_low = busy && (int'(us_q) < low_us);
  assign spu_en         = spu_q;
  assign rd_bit         = rd_q;
  assign presence       = pres_q;
  assign done           = done_q;

  // Slot sequencing and completion strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= K_IDLE;
      us_q   <= '0;
      wbit_q <= 1'b1;
      spu_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        us_q <= '0;
        case (op_in)
          OP_RESET: kind_q <= K_RESET;
          OP_WRITE: begin
            kind_q <= K_WRITE;
            wbit_q <= cmd_bit;
          end
          OP_READ:  kind_q <= K_READ;
          default: begin
            spu_q  <= cmd_bit;
            done_q <= 1'b1;
          end
        endcase
      end else if (busy && tick) begin
        if (slot_end) begin
          kind_q <= K_IDLE;
          us_q   <= '0;
          done_q <= 1'b1;
        end else begin
          us_q <= us_q + 1'b1;
        end
      end
    end
  end

  // Line sampling for read slots and presence detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      pres_q <= 1'b0;
    end else begin
      if (rd_evt)   rd_q   <= line_s;
      if (pres_evt) pres_q <= !line_s;
    end
  end
endmodule

// File: rtl/line_master_phy.sv
module line_master_phy #(
  parameter int CLK_PER_US    = 200,
  parameter int T_RST_LOW     = 480,
  parameter int T_RST_LISTEN  = 480,
  parameter int T_PRES_SAMPLE = 70,
  parameter int T_W1_LOW      = 6,
  parameter int T_W0_LOW      = 60,
  parameter int T_RD_LOW      = 6,
  parameter int T_RD_SAMPLE   = 10,
  parameter int T_SLOT        = 65,
  parameter int T_REC         = 5,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic       cmd_bit,
  input  logic       line_in,
  output logic       line_drive_low,
  output logic       spu_en,
  output logic       rd_bit,
  output logic       presence,
  output logic       done
);
  localparam int RST_TOTAL  = T_RST_LOW + T_RST_LISTEN;
  localparam int SLOT_TOTAL = T_SLOT + T_REC;

  logic tick_w, clear_w, line_s_w;
  logic busy_w, accept_w, slot_end_w, sample_evt_w;

  lmp_us_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (clear_w),
    .tick  (tick_w)
  );

  lmp_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_in (line_in),
    .line_s  (line_s_w)
  );

  lmp_slot_seq #(
    .T_RST_LOW     (T_RST_LOW),
    .T_PRES_SAMPLE (T_PRES_SAMPLE),
    .T_W1_LOW      (T_W1_LOW),
    .T_W0_LOW      (T_W0_LOW),
    .T_RD_LOW      (T_RD_LOW),
    .T_RD_SAMPLE   (T_RD_SAMPLE),
    .RST_TOTAL     (RST_TOTAL),
    .SLOT_TOTAL    (SLOT_TOTAL)
  ) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .tick           (tick_w),
    .cmd_valid      (cmd_valid),
    .cmd_op         (cmd_op),
    .cmd_bit        (cmd_bit),
    .line_s         (line_s_w),
    .tick_clear     (clear_w),
    .line_drive_low (line_drive_low),
    .spu_en         (spu_en),
    .rd_bit         (rd_bit),
    .presence       (presence),
    .done           (done),
    .busy           (busy_w),
    .accept         (accept_w),
    .slot_end       (slot_end_w),
    .sample_evt     (sample_evt_w)
  );
endmodule

// File: rtl/lmp_checker.sv
module lmp_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [1:0] cmd_op,
  input logic       line_drive_low,
  input logic       spu_en,
  input logic       done,
  input logic       busy,
  input logic       accept,
  input logic       slot_end,
  input logic       sample_evt
);
  // R6: pull-up and low drive never overlap
  a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_drive_low && spu_en));

  // R7: a slot request under strong pull-up leaves the line released
  a_r7_pullup_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (spu_en && cmd_valid && cmd_op != 2'd3) |=> !line_drive_low);

  // R8: commands during a slot cannot change the pull-up
  a_r8_busy_holds_pullup: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid) |=> $stable(spu_en));

  // R8: slot completion is followed by the done strobe
  a_r8_end_gives_done: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end |=> done);

  // R8: done is a single-cycle pulse unless a new pull-up op is taken
  a_r8_done_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !accept) |=> !done);

  // R2: an accepted reset pulls the line low on the next cycle
  a_r2_reset_pulls_low: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_op == 2'd0) |=> line_drive_low);

  // R5, R3: the line is sampled only after the master has released it
  a_r5_sample_released: assert property (@(posedge clk) disable iff (!rst_n)
    sample_evt |-> !line_drive_low);
endmodule

bind line_master_phy lmp_checker u_lmp_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .cmd_valid      (cmd_valid),
  .cmd_op         (cmd_op),
  .line_drive_low (line_drive_low),
  .spu_en         (spu_en),
  .done           (done),
  .busy           (busy_w),
  .accept         (accept_w),
  .slot_end       (slot_end_w),
  .sample_evt     (sample_evt_w)
);

// File: tb/line_master_phy_bench.sv
`timescale 1ns/1ps
module line_master_phy_bench;
  localparam int CPU = 4;  // clock cycles per microsecond in this bench

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic       cmd_bit = 1'b0;
  logic       slave_low = 1'b0;
  logic       line_in;
  logic       line_drive_low, spu_en, rd_bit, presence, done;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  int m_low, m_done_n, m_done_cnt;

  always #2.5 clk = ~clk;

  assign line_in = !(line_drive_low || slave_low);

  line_master_phy #(.CLK_PER_US(CPU)) u_line_master_phy (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_valid      (cmd_valid),
    .cmd_op         (cmd_op),
    .cmd_bit        (cmd_bit),
    .line_in        (line_in),
    .line_drive_low (line_drive_low),
    .spu_en         (spu_en),
    .rd_bit         (rd_bit),
    .presence       (presence),
    .done           (done)
  );

  // Expected timing restated from the requirements, in microseconds
  function automatic int exp_low(int op, logic b);
    if (op == 0) return 480;
    if (op == 1) return b ? 6 : 60;
    if (op == 2) return 6;
    return 0;
  endfunction

  function automatic int exp_end(int op);
    if (op == 0) return 960;
    if (op == 3) return 0;
    return 65 + 5;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Issue one operation, then watch for win cycles. inj_n > 0 injects a
  // second command (inj_op/inj_bit) at that cycle to test ignoring.
  task automatic run_op(int op, logic b, int win, int inj_n, int inj_op, logic inj_bit);
    m_low = 0; m_done_n = -1; m_done_cnt = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'(op); cmd_bit = b;
    for (int n = 1; n <= win; n++) begin
      @(negedge clk);
      if (line_drive_low) m_low++;
      if (done) begin
        m_done_cnt++;
        if (m_done_n < 0) m_done_n = n;
      end
      if (n == 1) cmd_valid = 1'b0;
      if (inj_n > 0 && n == inj_n) begin
        cmd_valid = 1'b1; cmd_op = 2'(inj_op); cmd_bit = inj_bit;
      end
      if (inj_n > 0 && n == inj_n + 1) cmd_valid = 1'b0;
    end
  endtask

  task automatic slave_read(int hold_cycles);
    @(posedge line_drive_low);
    @(negedge clk);
    slave_low = 1'b1;
    repeat (hold_cycles - 1) @(negedge clk);
    slave_low = 1'b0;
  endtask

  task automatic slave_presence(int wait_us, int hold_us);
    @(negedge line_drive_low);
    repeat (wait_us * CPU) @(negedge clk);
    slave_low = 1'b1;
    repeat (hold_us * CPU) @(negedge clk);
    slave_low = 1'b0;
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    check(line_drive_low == 1'b0, "R1 line released", int'(line_drive_low), 0);
    check(spu_en == 1'b0, "R1 pull-up off", int'(spu_en), 0);
    check(done == 1'b0, "R1 done low", int'(done), 0);
    check(presence == 1'b0 && rd_bit == 1'b0, "R1 presence/rd_bit zero",
          int'({presence, rd_bit}), 0);
  endtask

  task automatic t_reset_with_slave();
    fork
      run_op(0, 1'b0, exp_end(0) * CPU + 5, 0, 0, 1'b0);
      slave_presence(20, 100);
    join
    check(m_low == exp_low(0, 1'b0) * CPU, "R2 reset low time", m_low, exp_low(0, 1'b0) * CPU);
    check(m_done_n == exp_end(0) * CPU + 1, "R2 reset done cycle", m_done_n, exp_end(0) * CPU + 1);
    check(m_done_cnt == 1, "R8 single done after reset", m_done_cnt, 1);
    check(presence == 1'b1, "R3 presence seen", int'(presence), 1);
  endtask

  task automatic t_reset_late_slave();
    fork
      run_op(0, 1'b0, exp_end(0) * CPU + 5, 0, 0, 1'b0);
      slave_presence(80, 100);
    join
    check(presence == 1'b0, "R3 late responder not seen", int'(presence), 0);
    check(m_low == exp_low(0, 1'b0) * CPU, "R2 reset low time unaffected", m_low, exp_low(0, 1'b0) * CPU);
  endtask

  task automatic t_reset_none();
    run_op(0, 1'b0, exp_end(0) * CPU + 5, 0, 0, 1'b0);
    check(presence == 1'b0, "R3 no responder", int'(presence), 0);
  endtask

  task automatic t_write(logic b);
    run_op(1, b, exp_end(1) * CPU + 5, 0, 0, 1'b0);
    check(m_low == exp_low(1, b) * CPU, b ? "R4 write-1 low time" : "R4 write-0 low time",
          m_low, exp_low(1, b) * CPU);
    check(m_done_n == exp_end(1) * CPU + 1, "R4 write done cycle", m_done_n, exp_end(1) * CPU + 1);
  endtask

  task automatic t_read(int hold_us, logic exp_bit);
    if (hold_us > 0) begin
      fork
        run_op(2, 1'b0, exp_end(2) * CPU + 5, 0, 0, 1'b0);
        slave_read(hold_us * CPU);
      join
    end else begin
      run_op(2, 1'b0, exp_end(2) * CPU + 5, 0, 0, 1'b0);
    end
    check(rd_bit == exp_bit, "R5 read sampled level", int'(rd_bit), int'(exp_bit));
    check(m_low == exp_low(2, 1'b0) * CPU, "R5 read low time", m_low, exp_low(2, 1'b0) * CPU);
    check(m_done_n == exp_end(2) * CPU + 1, "R5 read done cycle", m_done_n, exp_end(2) * CPU + 1);
  endtask

  task automatic t_busy_ignore();
    run_op(2, 1'b0, exp_end(2) * CPU + 5, 10, 1, 1'b0);
    check(m_low == exp_low(2, 1'b0) * CPU, "R8 injected write ignored", m_low, exp_low(2, 1'b0) * CPU);
    check(m_done_cnt == 1, "R8 one done per op", m_done_cnt, 1);
    run_op(1, 1'b1, exp_end(1) * CPU + 5, 100, 3, 1'b1);
    check(spu_en == 1'b0, "R8 injected pull-up ignored", int'(spu_en), 0);
    check(m_done_cnt == 1, "R8 one done with pull-up injected", m_done_cnt, 1);
  endtask

  task automatic t_pullup();
    run_op(3, 1'b1, 4, 0, 0, 1'b0);
    check(spu_en == 1'b1, "R6 pull-up on", int'(spu_en), 1);
    check(m_done_n == 1, "R6 pull-up done next cycle", m_done_n, 1);
    check(m_low == 0, "R6 no low drive", m_low, 0);
    run_op(1, 1'b0, 300, 0, 0, 1'b0);
    check(m_low == 0 && m_done_cnt == 0, "R7 write blocked by pull-up", m_low + m_done_cnt, 0);
    run_op(0, 1'b0, 300, 0, 0, 1'b0);
    check(m_low == 0 && m_done_cnt == 0, "R7 reset blocked by pull-up", m_low + m_done_cnt, 0);
    run_op(3, 1'b0, 4, 0, 0, 1'b0);
    check(spu_en == 1'b0, "R6 pull-up off", int'(spu_en), 0);
    check(m_done_n == 1, "R6 pull-off done next cycle", m_done_n, 1);
    run_op(1, 1'b1, exp_end(1) * CPU + 5, 0, 0, 1'b0);
    check(m_low == exp_low(1, 1'b1) * CPU, "R7 slots resume after pull-up off",
          m_low, exp_low(1, 1'b1) * CPU);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_reset_with_slave();
    t_reset_late_slave();
    t_reset_none();
    t_write(1'b1);
    t_write(1'b0);
    t_read(9, 1'b1);
    t_read(11, 1'b0);
    t_read(0, 1'b1);
    t_busy_ignore();
    t_pullup();
    finished = 1'b1;
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
    end
  end
endmodule